// File: doc/BRIEF.md
# Pointer-Addressed Serial Register Target

This block is a target on a two-wire serial bus (I2C-style). It lets a bus master reach a small set of registers through an 8-bit pointer. SCL and SDA come in as raw levels. They pass through a synchronizer on a fast system clock, and the block finds START, repeated START and STOP conditions from them. The block acknowledges its own 7-bit address and drives SDA only through an open-drain enable, where a high `sda_oe` pulls the line low.

In a write, the first data byte after the address sets the pointer. Any further bytes go to the register the pointer selects: one byte for the 8-bit configuration register, and high byte then low byte for the two 16-bit limit registers. A read returns the selected register, high byte first. The pointer never advances by itself, so repeated reads return the same register until a new pointer is written.

A pointer write of 4 sends a one-cycle trigger to a measurement engine. Each address match sends a one-cycle access strobe. The three low address bits come from strap pins. These pins are frozen on the second address match, so later changes on them have no effect. If SDA stays still for a set number of cycles in the middle of a transfer, the block releases the line.

Top module: `i2c_ptr_target`

## Requirements
- R1: The block acknowledges (holds SDA low in the 9th clock) an address byte whose upper seven bits equal binary 1001 followed by the straps {A2,A1,A0}, with bit 0 giving the direction (1 = read). Any other address is not acknowledged, and the block drives nothing until the next START, so a read clocked afterwards returns 0xFF.
- R2: In a write, the first byte after the address is loaded into the pointer. A write that carries only the pointer byte changes no data register.
- R3: With pointer 1 (configuration, 8 bits), the next written byte replaces the register. Any further bytes are acknowledged and discarded.
- R4: With pointer 2 (hysteresis limit) or pointer 3 (overtemperature limit), the bytes are taken high then low. The register changes only when the low byte arrives. A high byte followed by STOP leaves the register unchanged. A third or later byte is acknowledged and discarded.
- R5: A read sends bits MSB first and returns the register at the pointer. Pointers 0 and 4 return the temperature input, high byte first. Pointer 1 returns the configuration and then 0x00. Pointers 2 and 3 return high then low byte. Bytes past the register's width read 0x00. Pointer values above 4 read 0x00.
- R6: The pointer does not auto-increment. A second read with no pointer write in between returns the same register.
- R7: A write to pointer 0 (temperature, read-only) is acknowledged and has no effect. A write to a pointer above 4 is also ignored.
- R8: Each pointer write of value 4 gives exactly one one-cycle pulse on `oneshot_o`.
- R9: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START.
- R10: A repeated START begins a new address phase at once. This allows a pointer write followed by a read without a STOP. A STOP releases SDA on the next cycle.
- R11: The straps are compared live until the second matching address byte, and at that byte they are frozen. After that, strap changes have no effect on the address.
- R12: If SDA does not change for TIMEOUT_CYC system clocks while a transfer is under way, the block releases SDA and ignores SCL until a new START.
- R13: After reset the pointer is 0, configuration is 0x00, hysteresis limit is 0x4B00, overtemperature limit is 0x5000, and SDA is released.
- R14: `access_o` pulses for one cycle on each matched address byte and never on an address that does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when high |
| strap_i | input | 3 | Address strap pins {A2,A1,A0} |
| temp_i | input | 16 | Current temperature word from the measurement engine |
| cfg_o | output | 8 | Configuration register |
| hyst_o | output | 16 | Hysteresis limit register |
| ovt_o | output | 16 | Overtemperature limit register |
| oneshot_o | output | 1 | One-cycle measurement trigger |
| access_o | output | 1 | One-cycle strobe per matched address |

## Verification
Properties are checked on every cycle for the following. SDA is released the cycle after a STOP and the cycle after the idle timeout expires. The trigger and access strobes never last more than one cycle. The configuration register changes only on a first-data-byte commit, and the limit registers only on a low-byte commit. Once the straps are frozen, the frozen address never changes. The scenarios alone can show the rest of the behaviour: which addresses are acknowledged, the byte order and padding of reads, the fact that the pointer does not advance, that writes to the temperature register and partial 16-bit writes leave state untouched, the effect of a master NACK and of a repeated START, and the moment the straps become frozen.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and constants for the pointer-addressed serial target.
// Assumes an 8-bit pointer whose low values select the registers.
package i2c_tgt_pkg;

    // Transfer-level states of the bus engine
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_WDATA,
        S_ACK,
        S_TX,
        S_TXACK
    } link_state_t;

    localparam logic [7:0] PTR_TEMP    = 8'd0;
    localparam logic [7:0] PTR_CFG     = 8'd1;
    localparam logic [7:0] PTR_HYST    = 8'd2;
    localparam logic [7:0] PTR_OVT     = 8'd3;
    localparam logic [7:0] PTR_ONESHOT = 8'd4;

    // Byte position inside a transfer, saturating at 3 ("beyond width")
    function automatic logic [1:0] idx_next(input logic [1:0] idx);
        return (idx == 2'd3) ? idx : idx + 2'd1;
    endfunction

    // Selects one byte of a 16-bit word by position; positions past 1 read zero
    function automatic logic [7:0] word_byte(input logic [15:0] w, input logic [1:0] idx);
        case (idx)
            2'd0:    return w[15:8];
            2'd1:    return w[7:0];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
// Two-flop synchronizer and edge finder for the bus lines.
// Line 1 is SCL and line 0 is SDA. Both reset to the idle-high level.
// START and STOP are SDA edges seen while the synchronized SCL is high.
// Assumes clk is at least ten times the SCL rate.
module i2c_tgt_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall,
    output logic             bus_start,
    output logic             bus_stop
);
    localparam int SCL_IX = 1;
    localparam int SDA_IX = 0;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [2:0] pipe;
        // Two sync stages plus one history stage per line
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[1:0], din[i]};
        end
        assign level[i] = pipe[1];
        assign rise[i]  = pipe[1] & ~pipe[2];
        assign fall[i]  = ~pipe[1] & pipe[2];
    end

    assign bus_start = level[SCL_IX] & fall[SDA_IX];
    assign bus_stop  = level[SCL_IX] & rise[SDA_IX];

endmodule

// File: rtl/i2c_tgt_link.sv
// Bus engine: handles address matching, ACK generation, byte shifting in
// both directions, strap freezing and the idle timeout.
// Received bytes are handed to the register file as write strobes tagged
// with their position, and read bytes are fetched from it by position.
// Inputs are synchronized levels and one-cycle edge pulses.
module i2c_tgt_link
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] ADDR_PREFIX = 4'b1001,
    parameter int         TIMEOUT_CYC = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_r,
    input  logic       scl_f,
    input  logic       sda_s,
    input  logic       sda_edge,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic [2:0] strap_i,
    input  logic [7:0] rd_data,
    output logic [1:0] rd_idx,
    output logic       wr_stb,
    output logic [1:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       sda_oe,
    output logic       access_o,
    output logic       to_hit,
    output logic       straps_frozen,
    output logic [2:0] straps_eff
);
    localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

    link_state_t state;
    logic [3:0]  bitcnt;
    logic [7:0]  sr;
    logic [7:0]  tx;
    logic [1:0]  byte_idx;
    logic        rd_mode;
    logic        seen_one;
    logic [2:0]  strap_q;
    logic [TO_W-1:0] to_cnt;
    logic        addr_hit;

    assign straps_eff = straps_frozen ? strap_q : strap_i;
    assign addr_hit   = (sr[7:1] == {ADDR_PREFIX, straps_eff});
    assign to_hit     = (to_cnt == TO_W'(TIMEOUT_CYC));
    assign rd_idx     = byte_idx;

    // Counts cycles with no SDA change while a transfer is under way
    always_ff @(posedge clk) begin
        if (!rst_n || state == S_IDLE || sda_edge) to_cnt <= '0;
        else if (!to_hit)                          to_cnt <= to_cnt + 1'b1;
    end

    // Freezes the straps on the second matching address byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_one      <= 1'b0;
            straps_frozen <= 1'b0;
            strap_q       <= '0;
        end else if (state == S_ADDR && scl_f && bitcnt == 4'd8 && addr_hit
                     && !straps_frozen) begin
            if (seen_one) begin
                straps_frozen <= 1'b1;
                strap_q       <= strap_i;
            end else begin
                seen_one <= 1'b1;
            end
        end
    end

    // Main transfer sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            bitcnt   <= '0;
            sr       <= '0;
            tx       <= '0;
            byte_idx <= '0;
            rd_mode  <= 1'b0;
            sda_oe   <= 1'b0;
            wr_stb   <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            access_o <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            access_o <= 1'b0;
            if (bus_start) begin
                state  <= S_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (bus_stop || to_hit) begin
                state  <= S_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_WDATA: begin
                        if (scl_r) begin
                            sr     <= {sr[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_f && bitcnt == 4'd8) begin
                            if (state == S_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe   <= 1'b1;
                                    state    <= S_ACK;
                                    rd_mode  <= sr[0];
                                    byte_idx <= '0;
                                    access_o <= 1'b1;
                                end else begin
                                    state <= S_IDLE;
                                end
                            end else begin
                                wr_stb   <= 1'b1;
                                wr_data  <= sr;
                                wr_idx   <= byte_idx;
                                byte_idx <= idx_next(byte_idx);
                                sda_oe   <= 1'b1;
                                state    <= S_ACK;
                            end
                        end
                    end
                    S_ACK: begin
                        if (scl_f) begin
                            bitcnt <= '0;
                            if (rd_mode) begin
                                tx       <= rd_data;
                                sda_oe   <= ~rd_data[7];
                                byte_idx <= idx_next(byte_idx);
                                state    <= S_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= S_WDATA;
                            end
                        end
                    end
                    S_TX: begin
                        if (scl_r) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_f) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= S_TXACK;
                            end else begin
                                tx     <= {tx[6:0], 1'b0};
                                sda_oe <= ~tx[6];
                            end
                        end
                    end
                    S_TXACK: begin
                        if (scl_r && sda_s) begin
                            state <= S_IDLE;
                        end else if (scl_f) begin
                            bitcnt   <= '0;
                            tx       <= rd_data;
                            sda_oe   <= ~rd_data[7];
                            byte_idx <= idx_next(byte_idx);
                            state    <= S_TX;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_tgt_regs.sv
// Register file behind the pointer. Byte position 0 loads the pointer.
// Position 1 loads the configuration or stages a limit's high byte.
// Position 2 commits a limit. Position 3 and up are discarded.
// Temperature comes from outside and cannot be written.
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter logic [7:0]  CFG_RST  = 8'h00,
    parameter logic [15:0] HYST_RST = 16'h4B00,
    parameter logic [15:0] OVT_RST  = 16'h5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic [1:0]  wr_idx,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_idx,
    input  logic [15:0] temp_i,
    output logic [7:0]  rd_data,
    output logic [7:0]  cfg_o,
    output logic [15:0] hyst_o,
    output logic [15:0] ovt_o,
    output logic        oneshot_o
);
    logic [7:0] ptr;
    logic [7:0] hi_stage;

    // Applies a received byte according to its position and the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= PTR_TEMP;
            hi_stage <= '0;
            cfg_o    <= CFG_RST;
            hyst_o   <= HYST_RST;
            ovt_o    <= OVT_RST;
        end else if (wr_stb) begin
            case (wr_idx)
                2'd0: ptr <= wr_data;
                2'd1: begin
                    if (ptr == PTR_CFG) cfg_o <= wr_data;
                    else if (ptr == PTR_HYST || ptr == PTR_OVT) hi_stage <= wr_data;
                end
                2'd2: begin
                    if (ptr == PTR_HYST)     hyst_o <= {hi_stage, wr_data};
                    else if (ptr == PTR_OVT) ovt_o  <= {hi_stage, wr_data};
                end
                default: ;
            endcase
        end
    end

    // One-cycle trigger when the pointer is written with the one-shot code
    always_ff @(posedge clk) begin
        if (!rst_n) oneshot_o <= 1'b0;
        else        oneshot_o <= wr_stb && wr_idx == 2'd0 && wr_data == PTR_ONESHOT;
    end

    // Read byte for the current pointer and byte position
    always_comb begin
        case (ptr)
            PTR_TEMP, PTR_ONESHOT: rd_data = word_byte(temp_i, rd_idx);
            PTR_CFG:               rd_data = (rd_idx == 2'd0) ? cfg_o : 8'h00;
            PTR_HYST:              rd_data = word_byte(hyst_o, rd_idx);
            PTR_OVT:               rd_data = word_byte(ovt_o, rd_idx);
            default:               rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/i2c_ptr_target.sv
// Top of the pointer-addressed serial target. Connects the line
// synchronizer, the bus engine and the register file.
// SDA is driven only through sda_oe, where a high value pulls the line low.
module i2c_ptr_target #(
    parameter logic [3:0]  ADDR_PREFIX = 4'b1001,
    parameter int          TIMEOUT_CYC = 20000,
    parameter logic [15:0] HYST_RST    = 16'h4B00,
    parameter logic [15:0] OVT_RST     = 16'h5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [2:0]  strap_i,
    input  logic [15:0] temp_i,
    output logic [7:0]  cfg_o,
    output logic [15:0] hyst_o,
    output logic [15:0] ovt_o,
    output logic        oneshot_o,
    output logic        access_o
);
    logic [1:0] lvl, rse, fll;
    logic       bus_start, bus_stop;
    logic       wr_stb;
    logic [1:0] wr_idx, rd_idx;
    logic [7:0] wr_data, rd_data;
    logic       to_hit;
    logic       straps_frozen;
    logic [2:0] straps_eff;

    i2c_tgt_sync #(.LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}),
        .level(lvl), .rise(rse), .fall(fll),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_tgt_link #(.ADDR_PREFIX(ADDR_PREFIX), .TIMEOUT_CYC(TIMEOUT_CYC)) u_link (
        .clk(clk), .rst_n(rst_n),
        .scl_r(rse[1]), .scl_f(fll[1]), .sda_s(lvl[0]),
        .sda_edge(rse[0] | fll[0]),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .strap_i(strap_i), .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_oe(sda_oe), .access_o(access_o), .to_hit(to_hit),
        .straps_frozen(straps_frozen), .straps_eff(straps_eff)
    );

    i2c_tgt_regs #(.HYST_RST(HYST_RST), .OVT_RST(OVT_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .temp_i(temp_i), .rd_data(rd_data),
        .cfg_o(cfg_o), .hyst_o(hyst_o), .ovt_o(ovt_o), .oneshot_o(oneshot_o)
    );

endmodule

// File: rtl/i2c_ptr_target_chk.sv
// Cycle-level properties of the serial target, bound to its top.
// Observes the top's ports and the nets between its submodules.
module i2c_ptr_target_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe,
    input logic        bus_stop,
    input logic        to_hit,
    input logic        oneshot,
    input logic        access,
    input logic        wr_stb,
    input logic [1:0]  wr_idx,
    input logic [7:0]  cfg,
    input logic [15:0] hyst,
    input logic [15:0] ovt,
    input logic        frozen,
    input logic [2:0]  straps
);
    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe);
    // R12
    timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_hit |=> !sda_oe);
    // R8
    oneshot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot |=> !oneshot);
    // R14
    access_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !access);
    // R3
    cfg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(wr_stb && wr_idx == 2'd1));
    // R4
    limit_low_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hyst) || !$stable(ovt)) |-> $past(wr_stb && wr_idx == 2'd2));
    // R11
    strap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frozen) |-> frozen);
    // R11
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frozen) |-> $stable(straps));
endmodule

bind i2c_ptr_target i2c_ptr_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .bus_stop(bus_stop),
    .to_hit(to_hit), .oneshot(oneshot_o), .access(access_o),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .cfg(cfg_o), .hyst(hyst_o),
    .ovt(ovt_o), .frozen(straps_frozen), .straps(straps_eff)
);

// File: tb/i2c_ptr_target_tb_top.sv
// Bench for the serial target: a bus master model on a wired-AND SDA line,
// a table of write/read-back vectors, and directed corner cases.
module i2c_ptr_target_tb_top;
    localparam int TO_CYC = 1000;
    localparam time Q = 100ns;
    localparam time H = 200ns;
    localparam logic [6:0] ADR = 7'b1001011;   // straps frozen at 3'b011

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic [15:0] temp = 16'h1930;
    logic sda_oe, oneshot_o, access_o;
    logic [7:0] cfg_o;
    logic [15:0] hyst_o, ovt_o;
    wire sda_bus = m_sda & ~sda_oe;

    int total = 0, failed = 0, os_cnt = 0, acc_cnt = 0;
    bit done = 1'b0;

    always #10ns clk = ~clk;

    i2c_ptr_target #(.TIMEOUT_CYC(TO_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_i(strap), .temp_i(temp), .cfg_o(cfg_o), .hyst_o(hyst_o),
        .ovt_o(ovt_o), .oneshot_o(oneshot_o), .access_o(access_o)
    );

    always @(posedge clk) begin
        if (oneshot_o) os_cnt++;
        if (access_o)  acc_cnt++;
    end

    // {ptr, byte count, data0, data1, expected 2-byte read}
    localparam logic [47:0] VEC [5] = '{
        {8'h01, 8'd1, 8'hA5, 8'h00, 16'hA500},
        {8'h02, 8'd2, 8'h12, 8'h34, 16'h1234},
        {8'h03, 8'd2, 8'hF0, 8'h0F, 16'hF00F},
        {8'h02, 8'd2, 8'h80, 8'h01, 16'h8001},
        {8'h01, 8'd1, 8'h3C, 8'h00, 16'h3C00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bstart();
        m_sda = 1'b0; #H; m_scl = 1'b0; #Q;
    endtask
    task automatic brstart();
        m_sda = 1'b1; #Q; m_scl = 1'b1; #H; m_sda = 1'b0; #H; m_scl = 1'b0; #Q;
    endtask
    task automatic bstop();
        m_sda = 1'b0; #Q; m_scl = 1'b1; #H; m_sda = 1'b1; #H;
    endtask
    task automatic bit_out(input logic b);
        m_sda = b; #Q; m_scl = 1'b1; #H; m_scl = 1'b0; #Q;
    endtask
    task automatic bit_in(output logic b);
        m_sda = 1'b1; #Q; m_scl = 1'b1; #(H/2); b = sda_bus; #(H/2); m_scl = 1'b0; #Q;
    endtask
    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = !b;
    endtask
    task automatic rbyte(output logic [7:0] d, input logic mack);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(!mack);
    endtask

    // Write transaction of up to three data bytes; returns AND of all ACKs
    task automatic wr_txn(input logic [7:0] p, input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2, output logic all_ack);
        logic a;
        bstart(); wbyte({ADR, 1'b0}, a); all_ack = a;
        wbyte(p, a); all_ack &= a;
        if (n > 0) begin wbyte(d0, a); all_ack &= a; end
        if (n > 1) begin wbyte(d1, a); all_ack &= a; end
        if (n > 2) begin wbyte(d2, a); all_ack &= a; end
        bstop();
    endtask

    task automatic rd_txn(output logic [15:0] w);
        logic a;
        logic [7:0] b0, b1;
        bstart(); wbyte({ADR, 1'b1}, a);
        rbyte(b0, 1'b1); rbyte(b1, 1'b0); bstop();
        w = {b0, b1};
    endtask

    initial begin
        logic a, all;
        logic [7:0] b0, b1, b2;
        logic [15:0] w;
        int os0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R13 reset values
        chk("R13 cfg", cfg_o, 8'h00);
        chk("R13 hyst", hyst_o, 16'h4B00);
        chk("R13 ovt", ovt_o, 16'h5000);
        chk("R13 sda_oe", sda_oe, 1'b0);

        // First match with straps 101: live strap compare, pointer 0 reads temp
        bstart(); wbyte({7'b1001101, 1'b1}, a); chk("R1 ack own addr", a, 1'b1);
        rbyte(b0, 1'b1); rbyte(b1, 1'b0); bstop();
        chk("R13 pointer 0 after reset", {b0, b1}, 16'h1930);

        // R11: second match freezes straps 011
        strap = 3'b011;
        bstart(); wbyte({7'b1001011, 1'b0}, a); chk("R11 second match ack", a, 1'b1);
        wbyte(8'h00, a); bstop();
        strap = 3'b000;
        bstart(); wbyte({7'b1001000, 1'b0}, a); bstop();
        chk("R11 new strap ignored", a, 1'b0);
        bstart(); wbyte({ADR, 1'b0}, a); bstop();
        chk("R11 frozen addr ack", a, 1'b1);
        chk("R14 access pulses", acc_cnt, 3);

        // R1: foreign address gets NACK and no drive
        bstart(); wbyte({7'b1001111, 1'b1}, a); chk("R1 foreign nack", a, 1'b0);
        rbyte(b0, 1'b0); bstop();
        chk("R1 no drive after nack", b0, 8'hFF);
        chk("R14 no access on mismatch", acc_cnt, 3);

        // Vector table: write then read back (R3, R4, R5)
        foreach (VEC[i]) begin
            wr_txn(VEC[i][47:40], int'(VEC[i][39:32]), VEC[i][31:24], VEC[i][23:16], 8'h00, all);
            chk("R2 table write acks", all, 1'b1);
            rd_txn(w);
            chk("R5 table readback", w, VEC[i][15:0]);
            case (VEC[i][47:40])
                8'h01:   chk("R3 cfg port", cfg_o, VEC[i][15:8]);
                8'h02:   chk("R4 hyst port", hyst_o, VEC[i][15:0]);
                default: chk("R4 ovt port", ovt_o, VEC[i][15:0]);
            endcase
        end

        // R4: high byte alone leaves limit untouched; third byte discarded
        wr_txn(8'h03, 1, 8'h77, 8'h00, 8'h00, all);
        chk("R4 partial write ignored", ovt_o, 16'hF00F);
        wr_txn(8'h02, 3, 8'hAB, 8'hCD, 8'hEE, all);
        chk("R4 extra byte acked", all, 1'b1);
        chk("R4 extra byte discarded", hyst_o, 16'hABCD);

        // R3: extra byte to configuration acked and dropped
        wr_txn(8'h01, 2, 8'h5A, 8'h77, 8'h00, all);
        chk("R3 extra byte acked", all, 1'b1);
        chk("R3 cfg value", cfg_o, 8'h5A);

        // R2: pointer-only write; R6: repeated reads of same register
        wr_txn(8'h02, 0, 8'h00, 8'h00, 8'h00, all);
        chk("R2 regs untouched", {cfg_o, hyst_o, ovt_o}, {8'h5A, 16'hABCD, 16'hF00F});
        rd_txn(w); chk("R2 pointer selects hyst", w, 16'hABCD);
        bstart(); wbyte({ADR, 1'b1}, a);
        rbyte(b0, 1'b1); rbyte(b1, 1'b1); rbyte(b2, 1'b0); bstop();
        chk("R6 same register again", {b0, b1}, 16'hABCD);
        chk("R5 byte past width", b2, 8'h00);

        // R7: write to temperature is acked and ignored
        wr_txn(8'h00, 2, 8'h11, 8'h22, 8'h00, all);
        chk("R7 temp write acked", all, 1'b1);
        chk("R7 regs unchanged", {cfg_o, hyst_o, ovt_o}, {8'h5A, 16'hABCD, 16'hF00F});
        rd_txn(w); chk("R7 temp still input", w, 16'h1930);

        // R8: pointer 4 gives a single trigger and reads temperature
        os0 = os_cnt;
        wr_txn(8'h04, 0, 8'h00, 8'h00, 8'h00, all);
        chk("R8 one trigger", os_cnt - os0, 1);
        rd_txn(w); chk("R5 pointer 4 reads temp", w, 16'h1930);

        // R5: unmapped pointer reads zero; R7: its write ignored
        wr_txn(8'h07, 2, 8'h99, 8'h99, 8'h00, all);
        rd_txn(w); chk("R5 unmapped reads zero", w, 16'h0000);
        chk("R7 unmapped write ignored", {cfg_o, hyst_o, ovt_o}, {8'h5A, 16'hABCD, 16'hF00F});

        // R10: pointer write then repeated START into a read
        bstart(); wbyte({ADR, 1'b0}, a); wbyte(8'h03, a);
        brstart(); wbyte({ADR, 1'b1}, a); chk("R10 ack after rstart", a, 1'b1);
        rbyte(b0, 1'b1); rbyte(b1, 1'b0); bstop();
        chk("R10 read after rstart", {b0, b1}, 16'hF00F);

        // R9: master NACK ends the read
        bstart(); wbyte({ADR, 1'b1}, a); rbyte(b0, 1'b0);
        chk("R9 first byte", b0, 8'hF0);
        rbyte(b1, 1'b0); bstop();
        chk("R9 released after nack", b1, 8'hFF);

        // R12: idle timeout releases a driven SDA
        wr_txn(8'h00, 0, 8'h00, 8'h00, 8'h00, all);
        bstart(); wbyte({ADR, 1'b1}, a);
        repeat (900) @(negedge clk);
        chk("R12 still driving before timeout", sda_oe, 1'b1);
        repeat (200) @(negedge clk);
        chk("R12 released after timeout", sda_oe, 1'b0);
        rbyte(b0, 1'b0);
        chk("R12 silent until START", b0, 8'hFF);
        bstop();
        rd_txn(w); chk("R12 recovers on new START", w, 16'h1930);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog: got hung expected finished");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule